// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Pipeline

This block is a two-stage pipelined SIMD multiplier that works on two packed operands. It splits each operand into 16-bit lanes and offers two operations. The first is a byte multiply-accumulate. Inside each lane, the two bytes of operand A are read as unsigned values and the two bytes of operand B as signed values. The two byte products are added, and the sum is clamped to the signed 16-bit range. The second is a rounding fractional multiply. It forms the full signed 16x16 product and returns a rounded, scaled upper part, which suits Q15 arithmetic.

A caller presents both operands together with an operation select, a width mode and a valid strobe. The result appears two clock cycles later with its own valid flag. The full width mode fills every lane. The half width mode fills only the lower half of the lanes and drives the upper half to zero. Between valid results the output register keeps its last value.

Top module: `simd_fxmul`

## Requirements
- R1: While rst_n is low, out_valid and result are both zero on the clock edge that follows.
- R2: out_valid is high in exactly the cycle that comes two clock edges after a cycle in which in_valid was high. A new operation can be accepted on every cycle.
- R3: With op_round=0, result lane i (bits 16i+15:16i) equals a(2i)*b(2i) + a(2i+1)*b(2i+1). Here a(k) is byte k of opa, read as unsigned, and b(k) is byte k of opb, read as signed (byte k sits at bits 8k+7:8k).
- R4: With op_round=0, a pair sum above 32767 gives 0x7FFF, and a pair sum below -32768 gives 0x8000.
- R5: With op_round=1, result lane i is formed in three steps. Take P, the signed 32-bit product of the 16-bit lanes of opa and opb. Shift P arithmetically right by 14 and add 1. Lane i is bits 16:1 of that value.
- R6: With op_round=1, the product 0x8000 * 0x8000 gives 0x8000 in that lane, because the value wraps.
- R7: wide=1 produces all eight 16-bit lanes. wide=0 produces lanes 0 to 3 and forces result bits 127:64 to zero.
- R8: In a cycle that comes two edges after in_valid was low, result keeps its previous value, whatever opa, opb, op_round and wide are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_round | input | 1 | 0 = byte multiply-accumulate with saturation, 1 = rounding fractional multiply |
| wide | input | 1 | 1 = full width (8 lanes), 0 = half width (4 lanes) |
| opa | input | 128 | First operand (unsigned bytes, or signed 16-bit lanes) |
| opb | input | 128 | Second operand (signed bytes, or signed 16-bit lanes) |
| out_valid | output | 1 | result holds a new value |
| result | output | 128 | Eight packed 16-bit results |

## Verification
The bench builds the block with its default of eight lanes, which gives a 128-bit datapath. With this setting the half width mode leaves four upper lanes whose zeroing can be observed, including a lane that holds a non-zero value in the matching full width vector. The vectors drive both saturation limits, the exact wraparound corner of the rounding multiply, negative products that round toward the most negative value, and a run of back-to-back operations. Directed steps then cover output hold while idle and a reset in the middle of operation.

// File: rtl/simd_fxmul.sv
module simd_fxmul #(
  parameter int NLANES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 op_round,
  input  logic                 wide,
  input  logic [NLANES*16-1:0] opa,
  input  logic [NLANES*16-1:0] opb,
  output logic                 out_valid,
  output logic [NLANES*16-1:0] result
);
  localparam int W    = NLANES * 16;
  localparam int HALF = NLANES / 2;

  logic         v1, op_q, wide_q, wide_out;
  logic [W-1:0] next_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
      op_q      <= 1'b0;
      wide_q    <= 1'b0;
      wide_out  <= 1'b0;
      result    <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) begin
        op_q   <= op_round;
        wide_q <= wide;
      end
      if (v1) begin
        result   <= next_res;
        wide_out <= wide_q;
      end
    end
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic        [7:0]  a0, a1, b0, b1;
    logic signed [16:0] m0, m1, m0_q, m1_q;
    logic signed [31:0] mw;
    logic        [16:0] mw_q;
    logic signed [17:0] sum;
    logic        [15:0] sat, rnd, lane;
    logic               unused_bits;

    assign a0 = opa[16*g +: 8];
    assign a1 = opa[16*g+8 +: 8];
    assign b0 = opb[16*g +: 8];
    assign b1 = opb[16*g+8 +: 8];
    assign m0 = $signed({1'b0, a0}) * $signed(b0);
    assign m1 = $signed({1'b0, a1}) * $signed(b1);
    assign mw = $signed(opa[16*g +: 16]) * $signed(opb[16*g +: 16]);
    assign unused_bits = ^{mw[31], mw[13:0]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m0_q <= '0;
        m1_q <= '0;
        mw_q <= '0;
      end else if (in_valid) begin
        m0_q <= m0;
        m1_q <= m1;
        mw_q <= mw[30:14];
      end
    end

    assign sum = m0_q + m1_q;
    assign sat = (sum[17:15] == 3'b000 || sum[17:15] == 3'b111) ? sum[15:0]
               : (sum[17] ? 16'h8000 : 16'h7FFF);
    assign rnd = mw_q[16:1] + {15'd0, mw_q[0]};

    if (g >= HALF) begin : g_upper
      assign lane = wide_q ? (op_q ? rnd : sat) : 16'h0000;
    end else begin : g_lower
      assign lane = op_q ? rnd : sat;
    end
    assign next_res[16*g +: 16] = lane;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  p_two_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 $stable(result));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_out) |-> (result[W-1:W/2] == '0));
endmodule

// File: tb/sim_simd_fxmul.sv
module sim_simd_fxmul;
  localparam int W = 128;
  localparam int NV = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         op_round = 1'b0;
  logic         wide = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         out_valid;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  simd_fxmul #(.NLANES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_round(op_round),
    .wide(wide), .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  // {op_round, wide}
  localparam logic [1:0] VMODE [NV] = '{2'b01, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01};
  localparam logic [W-1:0] VA [NV] = '{
    128'h0000_0000_0000_0000_0000_0000_0010_02FF,
    128'h8080_0000_0000_0000_0000_0000_FFFF_FFFF,
    128'h8080_0000_0000_0000_0000_0000_FFFF_FFFF,
    128'h0000_0001_0003_8000_FFFF_8000_7FFF_4000,
    128'h0000_0001_0003_8000_FFFF_8000_7FFF_4000,
    128'h0101_0101_0101_0101_0101_0101_0101_0101};
  localparam logic [W-1:0] VB [NV] = '{
    128'h0000_0000_0000_0000_0000_0000_00FF_0302,
    128'h007F_0000_0000_0000_0000_0000_8080_7F7F,
    128'h007F_0000_0000_0000_0000_0000_8080_7F7F,
    128'h0000_2000_2000_7FFF_0001_8000_7FFF_4000,
    128'h0000_2000_2000_7FFF_0001_8000_7FFF_4000,
    128'h0101_0101_0101_0101_0101_0101_0101_0101};
  localparam logic [W-1:0] VEXP [NV] = '{
    128'h0000_0000_0000_0000_0000_0000_FFF0_0204,
    128'h3F80_0000_0000_0000_0000_0000_8000_7FFF,
    128'h0000_0000_0000_0000_0000_0000_8000_7FFF,
    128'h0000_0000_0001_8001_0000_8000_7FFE_2000,
    128'h0000_0000_0000_0000_0000_8000_7FFE_2000,
    128'h0002_0002_0002_0002_0002_0002_0002_0002};
  localparam string VTAG [NV] = '{"R3", "R4", "R4/R7", "R5/R6", "R5/R7", "R3"};

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int k);
    op_round = VMODE[k][1];
    wide     = VMODE[k][0];
    opa      = VA[k];
    opb      = VB[k];
    in_valid = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", W'(out_valid), W'(0));
    chk("R1 result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(k);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 early", W'(out_valid), W'(0));
      @(negedge clk);
      chk("R2 valid", W'(out_valid), W'(1));
      chk(VTAG[k], result, VEXP[k]);
      @(negedge clk);
    end

    // R2/R3: back-to-back issue
    drive(0);
    @(negedge clk);
    drive(5);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 b2b first valid", W'(out_valid), W'(1));
    chk("R3 b2b first", result, VEXP[0]);
    @(negedge clk);
    chk("R2 b2b second valid", W'(out_valid), W'(1));
    chk("R3 b2b second", result, VEXP[5]);

    // R8: idle inputs toggle, result must hold
    opa = '1; opb = '1; op_round = 1'b1; wide = 1'b0;
    @(negedge clk);
    chk("R8 valid low", W'(out_valid), W'(0));
    @(negedge clk);
    chk("R8 hold", result, VEXP[5]);
    opa = 128'h1234; opb = 128'h5678; op_round = 1'b0;
    @(negedge clk);
    chk("R8 hold again", result, VEXP[5]);

    // R6: isolated corner with narrow mode
    op_round = 1'b1; wide = 1'b0;
    opa = 128'h8000; opb = 128'h8000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R6 corner", result, 128'h8000);

    // R1: reset in mid-operation
    @(negedge clk);
    drive(1);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid valid", W'(out_valid), W'(0));
    chk("R1 mid result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", W'(out_valid), W'(0));

    finish_run();
  end
endmodule